// File: doc/BRIEF.md
# Multibank Row and Burst Controller

This block follows a command stream sampled on the rising clock edge and keeps track of which row, if any, is open in each of four memory banks. An activate command opens a row in one bank. A read or write names a bank and a column, and it starts a burst that produces two column addresses per clock, one for each half of the clock. A precharge closes one bank or all of them. Commands that do not fit the current bank state are rejected and reported on a one-cycle error flag.

A burst is 4 or 8 beats long. The two low column bits of the command are discarded. A burst of 8 counts up from its start and wraps inside its aligned block of eight columns. A read or write may carry an auto-precharge request. In that case the bank closes by itself at the end of the burst. While a burst is running, other banks can still be activated or precharged. A new read or write is accepted only in the last cycle of the current burst, so bursts can run back to back with no gap. A controller places this block in front of its data path. It uses the beat columns to sequence the core array and uses the error flag to catch protocol faults.

Top module: `bank_burst_ctrl`

## Requirements
- R1: After reset every bank is closed, `beat_valid_o` is low and `err_o` is low.
- R2: An activate (`cmd` = 1) to a closed bank opens it. From the next cycle, `bank_open_o[b]` is high and the row appears in `open_row_o[b*ROW_W +: ROW_W]`.
- R3: An activate to a bank that is already open sets `err_o` high for exactly one cycle and leaves every recorded row and open flag unchanged.
- R4: A read (`cmd` = 2) or write (`cmd` = 3) to a closed bank sets `err_o` high for one cycle and starts no burst.
- R5: A burst with `cmd_bl8` low runs for 2 cycles, starting in the cycle after the command. Column bits [1:0] of the command are treated as zero. Each cycle presents the pair (c, c+1), then (c+2, c+3), where c is the aligned start column. `beat_write_o` is high for a write and `beat_bank_o` gives the bank.
- R6: A burst with `cmd_bl8` high runs for 4 cycles. The column counts up from the aligned start and wraps inside its aligned block of 8 columns, so a start of 4 within the block gives 4,5,6,7,0,1,2,3.
- R7: A read or write issued during any burst cycle except the last is refused with `err_o`. One issued in the last cycle is accepted, and its first beats follow with no idle cycle.
- R8: A read or write with `cmd_ap` high closes its bank at the clock edge that ends the burst's last cycle. A later activate to that bank is then accepted without error.
- R9: A precharge (`cmd` = 4) closes the bank named by `cmd_bank`. With `cmd_all` high it closes every bank. A precharge to a closed bank is not an error.
- R10: Activates and precharges to other banks take effect while a burst is running, and the burst continues undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code: 0 none, 1 activate, 2 read, 3 write, 4 precharge; others are ignored |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| cmd_addr | input | ROW_W | Row for an activate; column in the low COL_W bits for a read or write |
| cmd_ap | input | 1 | Auto-precharge request for a read or write |
| cmd_all | input | 1 | Precharge applies to every bank |
| cmd_bl8 | input | 1 | Burst of 8 when high, burst of 4 when low |
| err_o | output | 1 | One-cycle flag for a rejected command |
| bank_open_o | output | NUM_BANKS | Per-bank open flag |
| open_row_o | output | NUM_BANKS*ROW_W | Recorded row of each bank, bank 0 in the low bits |
| beat_valid_o | output | 1 | A burst cycle is being presented |
| beat_write_o | output | 1 | The current burst is a write |
| beat_bank_o | output | BANK_W | Bank of the current burst |
| beat_col_a_o | output | COL_W | Column of the first half-cycle beat |
| beat_col_b_o | output | COL_W | Column of the second half-cycle beat |

## Verification
The bench instantiates the block with its default parameters: four banks, 12-bit rows and 9-bit columns. With these values, start columns near the top of the 9-bit range show that the upper column bits pass through while the low bits are cleared or wrapped. Rows with distinct bit patterns in each bank show that each bank's row register is kept separate. Four banks also allow one bank to burst while a second is activated and precharged, and a third and fourth test the all-banks precharge.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4
   } cmd_e;
endpackage

// File: rtl/bbc_bank_table.sv
module bbc_bank_table #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       act_en_i,
   input  logic [BANK_W-1:0]          act_bank_i,
   input  logic [ROW_W-1:0]           act_row_i,
   input  logic                       pre_en_i,
   input  logic                       pre_all_i,
   input  logic [BANK_W-1:0]          pre_bank_i,
   input  logic                       ap_close_i,
   input  logic [BANK_W-1:0]          ap_bank_i,
   output logic [NUM_BANKS-1:0]       open_o,
   output logic [NUM_BANKS*ROW_W-1:0] row_o
);
   logic [NUM_BANKS-1:0] open_q;

   for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
      logic [ROW_W-1:0] row_q;
      logic             set_w, clr_w;
      assign set_w = act_en_i && (act_bank_i == BANK_W'(gi));
      assign clr_w = (pre_en_i && (pre_all_i || (pre_bank_i == BANK_W'(gi))))
                   || (ap_close_i && (ap_bank_i == BANK_W'(gi)));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_q[gi] <= 1'b0;
            row_q      <= '0;
         end else if (set_w) begin
            open_q[gi] <= 1'b1;
            row_q      <= act_row_i;
         end else if (clr_w) begin
            open_q[gi] <= 1'b0;
         end
      end
      assign row_o[gi*ROW_W +: ROW_W] = row_q;
   end

   assign open_o = open_q;

   // R2
   act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_en_i |=> open_q[$past(act_bank_i)]);
   // R9
   pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_en_i && pre_all_i && !act_en_i) |=> (open_q == '0));
endmodule

// File: rtl/bbc_burst_gen.sv
module bbc_burst_gen #(
   parameter int BANK_W = 2,
   parameter int COL_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              start_wr_i,
   input  logic              start_ap_i,
   input  logic              start_bl8_i,
   input  logic [BANK_W-1:0] start_bank_i,
   input  logic [COL_W-1:0]  start_col_i,
   output logic              beat_valid_o,
   output logic              beat_wr_o,
   output logic [BANK_W-1:0] beat_bank_o,
   output logic [COL_W-1:0]  beat_col_a_o,
   output logic [COL_W-1:0]  beat_col_b_o,
   output logic              last_o,
   output logic              ap_close_o,
   output logic [BANK_W-1:0] ap_bank_o
);
   if (COL_W < 3) begin : g_col_chk
      $error("bbc_burst_gen: COL_W must cover a block of 8 columns");
   end

   logic              active_q, wr_q, ap_q, bl8_q;
   logic [BANK_W-1:0] bank_q;
   logic [COL_W-1:0]  col_q;
   logic [1:0]        cnt_q;

   function automatic logic [COL_W-1:0] col_at(input logic [COL_W-1:0] base,
                                               input logic bl8,
                                               input logic [2:0] idx);
      if (bl8) return {base[COL_W-1:3], base[2] ^ idx[2], idx[1:0]};
      else     return {base[COL_W-1:2], idx[1:0]};
   endfunction

   assign last_o = active_q && (cnt_q == (bl8_q ? 2'd3 : 2'd1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         wr_q     <= 1'b0;
         ap_q     <= 1'b0;
         bl8_q    <= 1'b0;
         bank_q   <= '0;
         col_q    <= '0;
         cnt_q    <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         wr_q     <= start_wr_i;
         ap_q     <= start_ap_i;
         bl8_q    <= start_bl8_i;
         bank_q   <= start_bank_i;
         col_q    <= {start_col_i[COL_W-1:2], 2'b00};
         cnt_q    <= '0;
      end else if (last_o) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         cnt_q    <= cnt_q + 2'd1;
      end
   end

   assign beat_valid_o = active_q;
   assign beat_wr_o    = wr_q;
   assign beat_bank_o  = bank_q;
   assign beat_col_a_o = col_at(col_q, bl8_q, {cnt_q, 1'b0});
   assign beat_col_b_o = col_at(col_q, bl8_q, {cnt_q, 1'b1});
   assign ap_close_o   = last_o && ap_q;
   assign ap_bank_o    = bank_q;

   // R5
   start_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (beat_valid_o && beat_col_a_o[1:0] == 2'b00));
   // R7
   burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !last_o) |=> (active_q && $stable(bank_q) && $stable(wr_q)));
endmodule

// File: rtl/bank_burst_ctrl.sv
module bank_burst_ctrl #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 9,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [2:0]                 cmd,
   input  logic [BANK_W-1:0]          cmd_bank,
   input  logic [ROW_W-1:0]           cmd_addr,
   input  logic                       cmd_ap,
   input  logic                       cmd_all,
   input  logic                       cmd_bl8,
   output logic                       err_o,
   output logic [NUM_BANKS-1:0]       bank_open_o,
   output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
   output logic                       beat_valid_o,
   output logic                       beat_write_o,
   output logic [BANK_W-1:0]          beat_bank_o,
   output logic [COL_W-1:0]           beat_col_a_o,
   output logic [COL_W-1:0]           beat_col_b_o
);
   import bbc_pkg::*;

   if (ROW_W < COL_W) begin : g_addr_chk
      $error("bank_burst_ctrl: ROW_W must be at least COL_W");
   end

   logic              is_act, is_rw, is_pre, bank_hit, ap_hit, busy;
   logic              act_ok, rw_ok, bad, err_q;
   logic              burst_last, ap_close;
   logic [BANK_W-1:0] ap_bank;

   assign is_act   = (cmd == CMD_ACT);
   assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
   assign is_pre   = (cmd == CMD_PRE);
   assign bank_hit = bank_open_o[cmd_bank];
   assign ap_hit   = ap_close && (ap_bank == cmd_bank);
   assign busy     = beat_valid_o && !burst_last;
   assign act_ok   = is_act && !bank_hit;
   assign rw_ok    = is_rw && bank_hit && !ap_hit && !busy;
   assign bad      = (is_act && bank_hit) || (is_rw && !rw_ok);

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= bad;
   end
   assign err_o = err_q;

   bbc_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) table_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_en_i   (act_ok),
      .act_bank_i (cmd_bank),
      .act_row_i  (cmd_addr),
      .pre_en_i   (is_pre),
      .pre_all_i  (cmd_all),
      .pre_bank_i (cmd_bank),
      .ap_close_i (ap_close),
      .ap_bank_i  (ap_bank),
      .open_o     (bank_open_o),
      .row_o      (open_row_o)
   );

   bbc_burst_gen #(.BANK_W(BANK_W), .COL_W(COL_W)) burst_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (rw_ok),
      .start_wr_i   (cmd == CMD_WR),
      .start_ap_i   (cmd_ap),
      .start_bl8_i  (cmd_bl8),
      .start_bank_i (cmd_bank),
      .start_col_i  (cmd_addr[COL_W-1:0]),
      .beat_valid_o (beat_valid_o),
      .beat_wr_o    (beat_write_o),
      .beat_bank_o  (beat_bank_o),
      .beat_col_a_o (beat_col_a_o),
      .beat_col_b_o (beat_col_b_o),
      .last_o       (burst_last),
      .ap_close_o   (ap_close),
      .ap_bank_o    (ap_bank)
   );

   // R3
   act_open_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && bank_open_o[cmd_bank]) |=> (err_o && $stable(open_row_o)));
   // R4
   rw_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rw && !bank_open_o[cmd_bank] && !beat_valid_o) |=> (err_o && !beat_valid_o));
   // R8
   ap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_close && !(is_act && cmd_bank == ap_bank)) |=> !bank_open_o[$past(ap_bank)]);
endmodule

// File: tb/bank_burst_ctrl_tb_top.sv
module bank_burst_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;
   localparam int RW = 12;
   localparam int CW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    cmd = 3'd0;
   logic [1:0]    cmd_bank = '0;
   logic [RW-1:0] cmd_addr = '0;
   logic          cmd_ap = 1'b0, cmd_all = 1'b0, cmd_bl8 = 1'b0;
   logic          err_o, beat_valid_o, beat_write_o;
   logic [NB-1:0] bank_open_o;
   logic [NB*RW-1:0] open_row_o;
   logic [1:0]    beat_bank_o;
   logic [CW-1:0] beat_col_a_o, beat_col_b_o;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_burst_ctrl #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
      .cmd_ap(cmd_ap), .cmd_all(cmd_all), .cmd_bl8(cmd_bl8), .err_o(err_o),
      .bank_open_o(bank_open_o), .open_row_o(open_row_o), .beat_valid_o(beat_valid_o),
      .beat_write_o(beat_write_o), .beat_bank_o(beat_bank_o),
      .beat_col_a_o(beat_col_a_o), .beat_col_b_o(beat_col_b_o));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   // Drives a command at the current falling edge; returns one cycle later.
   task automatic send(input logic [2:0] c, input logic [1:0] b, input logic [RW-1:0] a,
                       input logic ap, input logic all, input logic bl8);
      cmd = c; cmd_bank = b; cmd_addr = a; cmd_ap = ap; cmd_all = all; cmd_bl8 = bl8;
      @(negedge clk);
      cmd = 3'd0; cmd_ap = 1'b0; cmd_all = 1'b0;
   endtask

   function automatic logic [CW-1:0] exp_col(input logic [CW-1:0] c, input logic bl8, input int k);
      logic [CW-1:0] base;
      int off;
      if (bl8) begin
         base = c & ~CW'(7);
         off  = (int'(c[2]) * 4 + k) % 8;
      end else begin
         base = c & ~CW'(3);
         off  = k % 4;
      end
      return base | CW'(off);
   endfunction

   function automatic logic [RW-1:0] row_of(input int b);
      return open_row_o[b*RW +: RW];
   endfunction

   // Checks every cycle of a burst starting at the current cycle.
   task automatic check_burst(input string req, input logic [1:0] b, input logic [CW-1:0] c,
                              input logic bl8, input logic wr);
      int ncyc;
      ncyc = bl8 ? 4 : 2;
      for (int k = 0; k < ncyc; k++) begin
         chk(req, beat_valid_o, 1'b1);
         chk(req, beat_bank_o, b);
         chk(req, beat_write_o, wr);
         chk(req, beat_col_a_o, exp_col(c, bl8, 2*k));
         chk(req, beat_col_b_o, exp_col(c, bl8, 2*k+1));
         @(negedge clk);
      end
      chk(req, beat_valid_o, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1", bank_open_o, '0);
      chk("R1", beat_valid_o, 1'b0);
      chk("R1", err_o, 1'b0);
   endtask

   task automatic t_activate();
      send(3'd1, 2'd0, 12'hABC, 0, 0, 0);
      chk("R2", bank_open_o, 4'b0001);
      chk("R2", row_of(0), 12'hABC);
      chk("R2", err_o, 1'b0);
      send(3'd1, 2'd3, 12'h5A5, 0, 0, 0);
      chk("R2", bank_open_o, 4'b1001);
      chk("R2", row_of(3), 12'h5A5);
   endtask

   task automatic t_bad_cmds();
      send(3'd1, 2'd0, 12'h111, 0, 0, 0);
      chk("R3", err_o, 1'b1);
      chk("R3", row_of(0), 12'hABC);
      chk("R3", bank_open_o, 4'b1001);
      @(negedge clk);
      chk("R3", err_o, 1'b0);
      send(3'd2, 2'd1, 12'h010, 0, 0, 0);
      chk("R4", err_o, 1'b1);
      chk("R4", beat_valid_o, 1'b0);
      send(3'd3, 2'd2, 12'h020, 0, 0, 1);
      chk("R4", err_o, 1'b1);
      chk("R4", beat_valid_o, 1'b0);
      @(negedge clk);
   endtask

   task automatic t_burst4();
      send(3'd2, 2'd0, 12'h1F3, 0, 0, 0);
      check_burst("R5", 2'd0, 9'h1F0, 1'b0, 1'b0);
      send(3'd3, 2'd3, 12'h006, 0, 0, 0);
      check_burst("R5", 2'd3, 9'h004, 1'b0, 1'b1);
   endtask

   task automatic t_burst8();
      send(3'd2, 2'd3, 12'h0A5, 0, 0, 1);
      check_burst("R6", 2'd3, 9'h0A4, 1'b1, 1'b0);
      send(3'd3, 2'd0, 12'h18B, 0, 0, 1);
      check_burst("R6", 2'd0, 9'h188, 1'b1, 1'b1);
   endtask

   task automatic t_busy();
      send(3'd2, 2'd0, 12'h040, 0, 0, 1);
      chk("R7", beat_col_a_o, 9'h040);
      send(3'd2, 2'd0, 12'h080, 0, 0, 0);
      chk("R7", err_o, 1'b1);
      chk("R7", beat_col_a_o, 9'h042);
      @(negedge clk);
      chk("R7", beat_col_a_o, 9'h044);
      @(negedge clk);
      chk("R7", beat_col_a_o, 9'h046);
      send(3'd3, 2'd3, 12'h0F3, 0, 0, 0);
      chk("R7", err_o, 1'b0);
      check_burst("R7", 2'd3, 9'h0F0, 1'b0, 1'b1);
   endtask

   task automatic t_autopre();
      send(3'd1, 2'd1, 12'h321, 0, 0, 0);
      chk("R8", bank_open_o[1], 1'b1);
      send(3'd2, 2'd1, 12'h008, 1, 0, 0);
      chk("R8", bank_open_o[1], 1'b1);
      chk("R8", beat_col_a_o, 9'h008);
      @(negedge clk);
      chk("R8", bank_open_o[1], 1'b1);
      @(negedge clk);
      chk("R8", bank_open_o[1], 1'b0);
      chk("R8", beat_valid_o, 1'b0);
      send(3'd1, 2'd1, 12'h654, 0, 0, 0);
      chk("R8", err_o, 1'b0);
      chk("R8", row_of(1), 12'h654);
   endtask

   task automatic t_concurrent();
      send(3'd2, 2'd0, 12'h000, 0, 0, 1);
      send(3'd1, 2'd2, 12'h777, 0, 0, 0);
      chk("R10", bank_open_o[2], 1'b1);
      chk("R10", row_of(2), 12'h777);
      chk("R10", beat_col_a_o, 9'h002);
      send(3'd4, 2'd2, 12'h000, 0, 0, 0);
      chk("R10", bank_open_o[2], 1'b0);
      chk("R10", bank_open_o[0], 1'b1);
      chk("R10", beat_col_a_o, 9'h004);
      chk("R10", beat_valid_o, 1'b1);
      @(negedge clk);
      chk("R10", beat_col_b_o, 9'h007);
      @(negedge clk);
      chk("R10", beat_valid_o, 1'b0);
   endtask

   task automatic t_precharge();
      chk("R9", bank_open_o, 4'b1011);
      send(3'd4, 2'd3, 12'h000, 0, 0, 0);
      chk("R9", bank_open_o, 4'b0011);
      chk("R9", err_o, 1'b0);
      send(3'd4, 2'd2, 12'h000, 0, 0, 0);
      chk("R9", err_o, 1'b0);
      chk("R9", bank_open_o, 4'b0011);
      send(3'd4, 2'd2, 12'h000, 0, 1, 0);
      chk("R9", bank_open_o, 4'b0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_activate();
      t_bad_cmds();
      t_burst4();
      t_burst8();
      t_busy();
      t_autopre();
      t_concurrent();
      t_precharge();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule